// File: doc/BRIEF.md
# Byte Register-File Operation Unit

This unit carries out single-operand byte operations on a bank of byte registers and on one working register, W. Each operation is issued by raising a start strobe for one clock cycle. On that strobe the unit presents an operation code, a register address and a destination bit. The whole operation finishes at the next clock edge. The addressed register is read combinationally, and its value is also shown on a read port so that the surrounding logic can observe the file.

There are four operations. Two of them clear state: one clears the addressed register and the other clears W. Both force the zero flag to 1. The other two, bitwise inversion and decrement by one, take the addressed register as their operand. The destination bit sends the result either into W or back into the same register, and the zero flag then reports whether the 8-bit result is zero. No carry is produced. A decrement of 00h wraps around to FFh.

The control is a single decode stage. It maps the operation code and the destination bit onto write enables for the file, for W and for the flag. Each operation takes one cycle, so the design has no multi-cycle state sequence.

Top module: `byte_fu_top`

## Requirements
- R1: After reset, W reads 00h, the zero flag reads 0 and every register in the file reads 00h.
- R2: Clear-register (op = 2'b00) writes 00h to the addressed register and sets the zero flag to 1. W is unchanged and the destination bit is ignored.
- R3: Clear-W (op = 2'b01) writes 00h to W and sets the zero flag to 1. No register in the file changes.
- R4: Invert (op = 2'b10) forms the bitwise complement of the addressed register. The result goes to W when dest = 0 and back to the register when dest = 1.
- R5: Decrement (op = 2'b11) forms the addressed register minus 1, modulo 256, so 00h becomes FFh. The result is routed by dest in the same way as R4.
- R6: For invert and decrement, the zero flag becomes 1 when the 8-bit result is 00h and 0 otherwise.
- R7: With dest = 0 the file is not written. With dest = 1, W is not written.
- R8: While start is low, W, the zero flag and the file all hold their values.
- R9: rd_data shows the current content of the register selected by addr in the same cycle, with no clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Issues one operation at this clock edge |
| op | input | 2 | Operation code: 00 clear reg, 01 clear W, 10 invert, 11 decrement |
| addr | input | 7 | Register address, 0 to 127 |
| dest | input | 1 | Destination: 0 selects W, 1 selects the addressed register |
| w_data | output | 8 | Working register W |
| z_flag | output | 1 | Zero flag |
| rd_data | output | 8 | Combinational read of the addressed register |

## Verification
The bench builds the unit with its default widths: a 7-bit address, which gives the full 128-entry file, and 8-bit data. With these widths the wrap from 00h to FFh and the zero result of inverting FFh both lie on the real byte boundary, and every address can be swept after reset. A behavioural model holding an integer array, W and the flag follows each cycle, including idle cycles with random operand values. Directed cases reach the zero, wrap and routing corners before a random sequence mixes all the operations.

// File: rtl/byte_fu_pkg.sv
package byte_fu_pkg;

    typedef enum logic [1:0] {
        OP_CLRREG = 2'b00,
        OP_CLRW   = 2'b01,
        OP_INV    = 2'b10,
        OP_DEC    = 2'b11
    } fu_op_e;

    typedef struct packed {
        logic wr_file;
        logic wr_w;
        logic wr_z;
    } fu_ctl_t;

endpackage

// File: rtl/fu_decode.sv
module fu_decode
    import byte_fu_pkg::*;
(
    input  logic    start,
    input  fu_op_e  op,
    input  logic    dest,
    output fu_ctl_t ctl
);
    always_comb begin
        ctl = '0;
        if (start) begin
            unique case (op)
                OP_CLRREG: begin
                    ctl.wr_file = 1'b1;
                    ctl.wr_z    = 1'b1;
                end
                OP_CLRW: begin
                    ctl.wr_w = 1'b1;
                    ctl.wr_z = 1'b1;
                end
                OP_INV, OP_DEC: begin
                    ctl.wr_file = dest;
                    ctl.wr_w    = ~dest;
                    ctl.wr_z    = 1'b1;
                end
                default: ctl = '0;
            endcase
        end
    end
endmodule

// File: rtl/fu_alu.sv
module fu_alu
    import byte_fu_pkg::*;
#(
    parameter int DW = 8
) (
    input  fu_op_e          op,
    input  logic [DW-1:0]   operand,
    output logic [DW-1:0]   result,
    output logic            is_zero
);
    localparam logic [DW-1:0] ONE = DW'(1);

    always_comb begin
        unique case (op)
            OP_CLRREG, OP_CLRW: result = '0;
            OP_INV:             result = ~operand;
            OP_DEC:             result = operand - ONE;
            default:            result = '0;
        endcase
    end

    assign is_zero = (result == '0);
endmodule

// File: rtl/fu_regfile.sv
module fu_regfile #(
    parameter int AW = 7,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[addr] <= wdata;
        end
    end

    assign rdata = mem[addr];
endmodule

// File: rtl/byte_fu_top.sv
module byte_fu_top
    import byte_fu_pkg::*;
#(
    parameter int AW = 7,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [1:0]    op,
    input  logic [AW-1:0] addr,
    input  logic          dest,
    output logic [DW-1:0] w_data,
    output logic          z_flag,
    output logic [DW-1:0] rd_data
);
    fu_op_e        op_e;
    fu_ctl_t       ctl;
    logic [DW-1:0] operand;
    logic [DW-1:0] result;
    logic          res_zero;
    logic [DW-1:0] w_q;
    logic          z_q;

    assign op_e = fu_op_e'(op);

    fu_decode u_dec (
        .start (start),
        .op    (op_e),
        .dest  (dest),
        .ctl   (ctl)
    );

    fu_regfile #(.AW(AW), .DW(DW)) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (ctl.wr_file),
        .addr  (addr),
        .wdata (result),
        .rdata (operand)
    );

    fu_alu #(.DW(DW)) u_alu (
        .op      (op_e),
        .operand (operand),
        .result  (result),
        .is_zero (res_zero)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            w_q <= '0;
            z_q <= 1'b0;
        end else begin
            if (ctl.wr_w) w_q <= result;
            if (ctl.wr_z) z_q <= res_zero;
        end
    end

    assign w_data  = w_q;
    assign z_flag  = z_q;
    assign rd_data = operand;
endmodule

// File: rtl/byte_fu_chk.sv
module byte_fu_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic [1:0]    op,
    input logic          dest,
    input logic [DW-1:0] w_data,
    input logic          z_flag,
    input logic [DW-1:0] rd_data
);
    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> ($stable(w_data) && $stable(z_flag)));

    // R2
    clr_sets_z_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !op[1]) |=> z_flag);

    // R3
    clrw_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && op == 2'b01) |=> (w_data == '0));

    // R2
    clrreg_keeps_w_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && op == 2'b00) |=> $stable(w_data));

    // R7
    file_dest_keeps_w_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && op[1] && dest) |=> $stable(w_data));

    // R6
    w_dest_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && op[1] && !dest) |=> (z_flag == (w_data == '0)));

    // R4
    inv_to_w_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && op == 2'b10 && !dest) |=> (w_data == ~$past(rd_data)));

    // R5
    dec_to_w_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && op == 2'b11 && !dest) |=> (w_data == $past(rd_data) - DW'(1)));
endmodule

bind byte_fu_top byte_fu_chk #(.DW(DW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .op      (op),
    .dest    (dest),
    .w_data  (w_data),
    .z_flag  (z_flag),
    .rd_data (rd_data)
);

// File: tb/sim_byte_fu_top.sv
`timescale 1ns/1ps
module sim_byte_fu_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [1:0] op = 2'b00;
    logic [6:0] addr = '0;
    logic       dest = 1'b0;
    logic [7:0] w_data;
    logic       z_flag;
    logic [7:0] rd_data;

    int errors = 0;
    int checks = 0;
    int mref [128];
    int wref = 0;
    int zref = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    byte_fu_top u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op),
        .addr(addr), .dest(dest), .w_data(w_data), .z_flag(z_flag),
        .rd_data(rd_data)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic run_op(input bit st, input int o, input int a, input bit d);
        int res;
        @(negedge clk);
        start = st; op = o[1:0]; addr = a[6:0]; dest = d;
        #1;
        chk("R9 rd_data", int'(rd_data), mref[a]);
        if (st) begin
            case (o)
                0: begin mref[a] = 0; zref = 1; end
                1: begin wref = 0; zref = 1; end
                default: begin
                    if (o == 2) res = (~mref[a]) & 8'hFF;
                    else        res = (mref[a] + 255) % 256;
                    if (d) mref[a] = res; else wref = res;
                    zref = (res == 0) ? 1 : 0;
                end
            endcase
        end
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        chk(st ? "R2-6 w_data" : "R8 w_data", int'(w_data), wref);
        chk(st ? "R6 z_flag" : "R8 z_flag", int'(z_flag), zref);
        #1;
        chk("R7 file entry", int'(rd_data), mref[a]);
    endtask

    initial begin
        for (int i = 0; i < 128; i++) mref[i] = 0;
        #12;
        chk("R1 w after reset", int'(w_data), 0);
        chk("R1 z after reset", int'(z_flag), 0);
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 128; i++) begin
            addr = i[6:0];
            #0.1;
            chk("R1 file after reset", int'(rd_data), 0);
        end
        // R4 invert to register: 00 -> FF, Z=0
        run_op(1, 2, 5, 1);
        // R5 decrement to register: FF -> FE
        run_op(1, 3, 5, 1);
        // R5 R7 decrement to W: W=FD, reg stays FE
        run_op(1, 3, 5, 0);
        // R4 invert of 00 to W: FF
        run_op(1, 2, 0, 0);
        // R5 wrap 00 -> FF in register
        run_op(1, 3, 9, 1);
        // R6 invert FF -> 00, Z=1
        run_op(1, 2, 9, 1);
        // R6 decrement 01 -> 00: make 01 by inverting FE
        run_op(1, 2, 5, 1);
        run_op(1, 3, 5, 0);
        // R2 clear register, dest ignored
        run_op(1, 2, 127, 1);
        run_op(1, 0, 127, 0);
        // R3 clear W
        run_op(1, 2, 3, 0);
        run_op(1, 1, 3, 1);
        // R8 start low with varied inputs
        run_op(0, 2, 5, 1);
        run_op(0, 0, 127, 0);
        for (int i = 0; i < 400; i++)
            run_op(($urandom % 4) != 0, $urandom % 4, $urandom % 8, $urandom % 2);
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                #(200000 * 5);
                errors++;
                checks++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule